// File: doc/BRIEF.md
# Write-Through Invalidate Snooping Cache Controller

This block is the coherence controller for one small direct-mapped, write-through cache on a shared snooping bus. The bus is atomic: one transaction runs to completion before the next one starts. Every line is either Valid or Invalid. A processor read that finds a Valid line with a matching tag is answered from the local copy. A read that misses requests the bus, fetches the word from memory, and fills the line.

Processor writes always go out on the bus as write transactions, and a write never allocates a line. A write that hits a Valid line refreshes the local copy and leaves the line Valid. The controller watches the bus for writes issued by other caches. A write from another cache to an address that this cache holds Valid invalidates that line during the transaction.

The processor holds its request until the controller signals completion. It issues nothing further until then.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, so the first read of any address uses the bus; `bus_req`, `bus_cmd_valid` and `cpu_done` are low out of reset.
- R2: A read that misses issues one bus read (`bus_cmd_we`=0), returns the memory word on `cpu_rdata`, and leaves the line Valid with the new tag.
- R3: A read that hits is answered from the cache with no bus transaction, and `cpu_done` rises one cycle after the request is first seen.
- R4: Every processor write issues exactly one bus write carrying the request's address and data, whatever the line state. A write miss does not allocate a line. A write hit updates the cached word and keeps the line Valid.
- R5: A bus write (`snp_valid`=1, `snp_we`=1) whose `snp_id` differs from `MY_ID` and whose address matches a Valid line makes that line Invalid. The next read of that address therefore misses and returns the memory value.
- R6: The following snoops leave the cache unchanged: a snoop with `snp_id` equal to `MY_ID`, a bus read (`snp_we`=0), and a bus write to the same index with a different tag.
- R7: `bus_req` is raised before any command. `bus_cmd_valid` rises only after `bus_gnt`, and the command and address stay unchanged until `bus_ack`.
- R8: If an invalidating snoop hits the line that a read hit would use in the same cycle, the invalidation wins. The read is not completed that cycle and is retried as a miss.
- R9: The line index is the low log2(LINES) address bits and the tag is the remaining upper bits. A read miss to the same index with a different tag replaces the previous line.
- R10: `cpu_done` is a single-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_done | output | 1 | Completion pulse |
| cpu_rdata | output | DW | Read data, valid with `cpu_done` |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_cmd_valid | output | 1 | Command phase active |
| bus_cmd_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Bus write data |
| bus_ack | input | 1 | Memory completes the transaction |
| bus_rdata | input | DW | Memory read data, valid with `bus_ack` |
| snp_valid | input | 1 | Observed bus transaction |
| snp_we | input | 1 | Observed transaction is a write |
| snp_id | input | ID_W | Issuer of the observed transaction |
| snp_addr | input | AW | Observed address |

## Verification
The bench builds the block with 4 lines, a 4-bit address and 8-bit data, which gives four indices and four tags per index. At that size it can sweep all sixteen addresses through miss, hit, write and eviction, and compare the results with a reference model of tags and Valid bits kept in the bench.

Each address is also put through every snoop variant: its own id, a bus read, a write with a different tag, and an invalidating write. The same-cycle conflict between a snoop and a read hit is exercised on every index.

// File: rtl/wti_pkg.sv
package wti_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARB,
        ST_XFER,
        ST_RESP
    } ctl_state_e;
endpackage

// File: rtl/wti_line_store.sv
module wti_line_store #(
    parameter int LINES = 8,
    parameter int TAG_W = 4,
    parameter int DW    = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [DW-1:0]    lk_data,
    input  logic             wr_en,
    input  logic             wr_alloc,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [DW-1:0]    wr_data,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic [TAG_W-1:0] inv_tag,
    output logic             inv_hit,
    output logic [LINES-1:0] vld_vec
);
    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [DW-1:0]    data;
    } line_t;

    line_t lines_view [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_t ln_d, ln_q;

        always_comb begin
            ln_d = ln_q;
            if (wr_en && wr_idx == IDX_W'(g)) begin
                if (wr_alloc) begin
                    ln_d.vld  = 1'b1;
                    ln_d.tag  = wr_tag;
                    ln_d.data = wr_data;
                end else if (ln_q.vld && ln_q.tag == wr_tag) begin
                    ln_d.data = wr_data;
                end
            end
            if (inv_en && inv_idx == IDX_W'(g) && ln_q.vld && ln_q.tag == inv_tag) begin
                ln_d.vld = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ln_q <= '0;
            else        ln_q <= ln_d;
        end

        assign lines_view[g] = ln_q;
        assign vld_vec[g]    = ln_q.vld;
    end

    assign lk_hit  = lines_view[lk_idx].vld && (lines_view[lk_idx].tag == lk_tag);
    assign lk_data = lines_view[lk_idx].data;
    assign inv_hit = lines_view[inv_idx].vld && (lines_view[inv_idx].tag == inv_tag);
endmodule

// File: rtl/wti_ctrl.sv
module wti_ctrl
    import wti_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    input  logic          lk_hit,
    input  logic [DW-1:0] lk_data,
    input  logic          snp_kill,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_cmd_valid,
    output logic          bus_cmd_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          wr_en,
    output logic          wr_alloc,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          idle
);
    typedef struct packed {
        ctl_state_e    st;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        wr_en    = 1'b0;
        wr_alloc = 1'b0;
        wr_data  = c_q.wdata;
        unique case (c_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    c_d.we    = cpu_we;
                    c_d.addr  = cpu_addr;
                    c_d.wdata = cpu_wdata;
                    if (snp_kill) begin
                        c_d.st = ST_IDLE;
                    end else if (!cpu_we && lk_hit) begin
                        c_d.rdata = lk_data;
                        c_d.st    = ST_RESP;
                    end else begin
                        c_d.st = ST_ARB;
                    end
                end
            end
            ST_ARB: begin
                if (bus_gnt) c_d.st = ST_XFER;
            end
            ST_XFER: begin
                if (bus_ack) begin
                    wr_en = 1'b1;
                    if (!c_q.we) begin
                        wr_alloc  = 1'b1;
                        wr_data   = bus_rdata;
                        c_d.rdata = bus_rdata;
                    end
                    c_d.st = ST_RESP;
                end
            end
            ST_RESP: c_d.st = ST_IDLE;
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign wr_addr       = c_q.addr;
    assign idle          = (c_q.st == ST_IDLE);
    assign cpu_done      = (c_q.st == ST_RESP);
    assign cpu_rdata     = c_q.rdata;
    assign bus_req       = (c_q.st == ST_ARB) || (c_q.st == ST_XFER);
    assign bus_cmd_valid = (c_q.st == ST_XFER);
    assign bus_cmd_we    = bus_cmd_valid && c_q.we;
    assign bus_addr      = bus_cmd_valid ? c_q.addr : '0;
    assign bus_wdata     = (bus_cmd_valid && c_q.we) ? c_q.wdata : '0;
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int LINES = 8,
    parameter int ID_W  = 2,
    parameter int MY_ID = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_req,
    input  logic            cpu_we,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [DW-1:0]   cpu_wdata,
    output logic            cpu_done,
    output logic [DW-1:0]   cpu_rdata,
    output logic            bus_req,
    input  logic            bus_gnt,
    output logic            bus_cmd_valid,
    output logic            bus_cmd_we,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    input  logic            bus_ack,
    input  logic [DW-1:0]   bus_rdata,
    input  logic            snp_valid,
    input  logic            snp_we,
    input  logic [ID_W-1:0] snp_id,
    input  logic [AW-1:0]   snp_addr
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = AW - IDX_W;

    logic             lk_hit, inv_hit, snoop_fire, snp_kill;
    logic             wr_en, wr_alloc, ctl_idle;
    logic [DW-1:0]    lk_data, wr_data;
    logic [AW-1:0]    wr_addr;
    logic [LINES-1:0] vld_vec;

    assign snoop_fire = snp_valid && snp_we && (snp_id != ID_W'(MY_ID));
    assign snp_kill   = snoop_fire && inv_hit &&
                        (snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]);

    wti_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (cpu_addr[IDX_W-1:0]),
        .lk_tag   (cpu_addr[AW-1:IDX_W]),
        .lk_hit   (lk_hit),
        .lk_data  (lk_data),
        .wr_en    (wr_en),
        .wr_alloc (wr_alloc),
        .wr_idx   (wr_addr[IDX_W-1:0]),
        .wr_tag   (wr_addr[AW-1:IDX_W]),
        .wr_data  (wr_data),
        .inv_en   (snoop_fire),
        .inv_idx  (snp_addr[IDX_W-1:0]),
        .inv_tag  (snp_addr[AW-1:IDX_W]),
        .inv_hit  (inv_hit),
        .vld_vec  (vld_vec)
    );

    wti_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req       (cpu_req),
        .cpu_we        (cpu_we),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_done      (cpu_done),
        .cpu_rdata     (cpu_rdata),
        .lk_hit        (lk_hit),
        .lk_data       (lk_data),
        .snp_kill      (snp_kill),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .bus_cmd_valid (bus_cmd_valid),
        .bus_cmd_we    (bus_cmd_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_ack       (bus_ack),
        .bus_rdata     (bus_rdata),
        .wr_en         (wr_en),
        .wr_alloc      (wr_alloc),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .idle          (ctl_idle)
    );
endmodule

// File: rtl/wti_checks.sv
module wti_checks #(
    parameter int AW    = 16,
    parameter int LINES = 8,
    parameter int ID_W  = 2,
    parameter int MY_ID = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_req,
    input logic             cpu_we,
    input logic             cpu_done,
    input logic             bus_req,
    input logic             bus_gnt,
    input logic             bus_cmd_valid,
    input logic             bus_ack,
    input logic [AW-1:0]    bus_addr,
    input logic             snp_valid,
    input logic [ID_W-1:0]  snp_id,
    input logic [AW-1:0]    snp_addr,
    input logic             snoop_fire,
    input logic             inv_hit,
    input logic             snp_kill,
    input logic             lk_hit,
    input logic             ctl_idle,
    input logic [LINES-1:0] vld_vec
);
    localparam int IDX_W = $clog2(LINES);
    logic [IDX_W-1:0] snp_idx;
    assign snp_idx = snp_addr[IDX_W-1:0];

    a_r3_hit_is_local: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_idle && cpu_req && !cpu_we && lk_hit && !snp_kill |=> cpu_done && !bus_req);

    a_r5_snoop_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_fire && inv_hit && !bus_cmd_valid |=> !vld_vec[$past(snp_idx)]);

    a_r6_own_snoop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_id == ID_W'(MY_ID) && !bus_cmd_valid |=> $stable(vld_vec));

    a_r7_cmd_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cmd_valid) |-> $past(bus_gnt));

    a_r7_cmd_under_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid |-> bus_req);

    a_r7_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid && !bus_ack |=> bus_cmd_valid && $stable(bus_addr));

    a_r8_conflict_retries: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_idle && cpu_req && snp_kill |=> !cpu_done);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);
endmodule

bind wt_snoop_cache wti_checks #(.AW(AW), .LINES(LINES), .ID_W(ID_W), .MY_ID(MY_ID)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req       (cpu_req),
    .cpu_we        (cpu_we),
    .cpu_done      (cpu_done),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .bus_cmd_valid (bus_cmd_valid),
    .bus_ack       (bus_ack),
    .bus_addr      (bus_addr),
    .snp_valid     (snp_valid),
    .snp_id        (snp_id),
    .snp_addr      (snp_addr),
    .snoop_fire    (snoop_fire),
    .inv_hit       (inv_hit),
    .snp_kill      (snp_kill),
    .lk_hit        (lk_hit),
    .ctl_idle      (ctl_idle),
    .vld_vec       (vld_vec)
);

// File: tb/sim_wt_snoop_cache.sv
module sim_wt_snoop_cache;
    localparam int AW = 4, DW = 8, LINES = 4, ID_W = 2, MY_ID = 1;

    logic clk = 0, rst_n = 0;
    logic cpu_req = 0, cpu_we = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic bus_req, bus_cmd_valid, bus_cmd_we;
    logic bus_gnt = 0, bus_ack = 0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata = '0;
    logic snp_valid = 0, snp_we = 0;
    logic [ID_W-1:0] snp_id = '0;
    logic [AW-1:0] snp_addr = '0;

    always #2 clk = ~clk;

    wt_snoop_cache #(.AW(AW), .DW(DW), .LINES(LINES), .ID_W(ID_W), .MY_ID(MY_ID)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
        .bus_cmd_we(bus_cmd_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_we(snp_we), .snp_id(snp_id), .snp_addr(snp_addr)
    );

    int checks = 0, fails = 0;
    int n_rd = 0, n_wr = 0, gnt_bad = 0;
    logic [DW-1:0] mem [16];
    logic [AW-1:0] last_addr;
    logic [DW-1:0] last_wdata;
    bit model_vld [LINES];
    logic [1:0] model_tag [LINES];
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // memory and arbiter responder
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_cmd_valid && !bus_gnt) gnt_bad++;
            bus_gnt = bus_req;
            if (bus_cmd_valid && !bus_ack) begin
                bus_ack = 1;
                bus_rdata = mem[bus_addr];
                last_addr = bus_addr;
                if (bus_cmd_we) begin
                    mem[bus_addr] = bus_wdata;
                    last_wdata = bus_wdata;
                    n_wr++;
                end else begin
                    n_rd++;
                end
            end else begin
                bus_ack = 0;
            end
        end
    end

    task automatic wait_done(output int lat);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_done && lat < 50);
        cpu_req = 0;
        chk(cpu_done, "R10", cpu_done, 1);
        @(negedge clk);
        chk(!cpu_done, "R10", cpu_done, 0);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string req, output bit used_bus);
        int rd0 = n_rd;
        int lat;
        bit exp_hit = model_vld[a[1:0]] && model_tag[a[1:0]] == a[3:2];
        cpu_we = 0; cpu_addr = a; cpu_req = 1;
        wait_done(lat);
        used_bus = (n_rd != rd0);
        chk(cpu_rdata == mem[a], req, cpu_rdata, mem[a]);
        if (exp_hit) begin
            chk(n_rd == rd0, {req, "/R3 no bus"}, n_rd - rd0, 0);
            chk(lat == 1, "R3 latency", lat, 1);
        end else begin
            chk(n_rd == rd0 + 1, {req, "/R2 bus read"}, n_rd - rd0, 1);
            chk(last_addr == a, "R2 addr", last_addr, a);
        end
        model_vld[a[1:0]] = 1;
        model_tag[a[1:0]] = a[3:2];
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int wr0 = n_wr;
        int lat;
        cpu_we = 1; cpu_addr = a; cpu_wdata = d; cpu_req = 1;
        wait_done(lat);
        chk(n_wr == wr0 + 1, "R4 bus write", n_wr - wr0, 1);
        chk(last_addr == a, "R4 addr", last_addr, a);
        chk(last_wdata == d, "R4 data", last_wdata, d);
    endtask

    task automatic snoop(input int id, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] nv);
        snp_valid = 1; snp_we = we; snp_id = ID_W'(id); snp_addr = a;
        if (we && id != MY_ID) mem[a] = nv;
        @(negedge clk);
        snp_valid = 0;
        if (we && id != MY_ID && model_vld[a[1:0]] && model_tag[a[1:0]] == a[3:2])
            model_vld[a[1:0]] = 0;
    endtask

    initial begin
        bit used;
        for (int i = 0; i < 16; i++) mem[i] = DW'(8'h10 + 7 * i);
        for (int i = 0; i < LINES; i++) begin model_vld[i] = 0; model_tag[i] = 0; end
        repeat (3) @(negedge clk);
        chk(!bus_req && !bus_cmd_valid && !cpu_done, "R1 reset outputs", bus_req, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!bus_req && !cpu_done, "R1 idle", bus_req, 0);

        // R1/R2/R3/R9 read sweep with eviction
        for (int a = 0; a < 16; a++) begin
            do_read(AW'(a), "R1 first read", used);
            chk(used, "R1 first read misses", used, 1);
            do_read(AW'(a), "R3 reread", used);
            chk(!used, "R3 reread hits", used, 0);
            if (a >= 4) begin
                do_read(AW'(a - 4), "R9 evicted", used);
                chk(used, "R9 eviction miss", used, 1);
            end
        end

        // R4 write sweep: bus write always, no allocate, hit updates copy
        for (int a = 0; a < 16; a++) begin
            do_write(AW'(a), DW'(8'hA0 + a));
            chk(mem[a] == DW'(8'hA0 + a), "R4 memory", mem[a], 8'hA0 + a);
            do_read(AW'(a), "R4 read after write", used);
        end

        // R5/R6 snoop variants on every address
        for (int a = 0; a < 16; a++) begin
            do_read(AW'(a), "R2 prime", used);
            snoop(MY_ID, 1, AW'(a), '0);
            do_read(AW'(a), "R6 own id", used);
            chk(!used, "R6 own snoop ignored", used, 0);
            snoop(2, 0, AW'(a), '0);
            do_read(AW'(a), "R6 bus read", used);
            chk(!used, "R6 read snoop ignored", used, 0);
            snoop(3, 1, AW'(a ^ 4), DW'(8'h55 + a));
            do_read(AW'(a), "R6 other tag", used);
            chk(!used, "R6 other tag ignored", used, 0);
            snoop(0, 1, AW'(a), DW'(8'hC0 + a));
            do_read(AW'(a), "R5 after invalidate", used);
            chk(used, "R5 invalidated line misses", used, 1);
        end

        // R8 same-cycle conflict between read hit and snoop
        for (int a = 0; a < 4; a++) begin
            int rd0, lat;
            do_read(AW'(a), "R2 prime", used);
            rd0 = n_rd;
            cpu_we = 0; cpu_addr = AW'(a); cpu_req = 1;
            snp_valid = 1; snp_we = 1; snp_id = 2'd2; snp_addr = AW'(a);
            mem[a] = DW'(8'hE0 + a);
            @(negedge clk);
            snp_valid = 0;
            chk(!cpu_done, "R8 no completion in conflict", cpu_done, 0);
            wait_done(lat);
            chk(cpu_rdata == DW'(8'hE0 + a), "R8 retried data", cpu_rdata, 8'hE0 + a);
            chk(n_rd == rd0 + 1, "R8 retried as miss", n_rd - rd0, 1);
        end

        chk(gnt_bad == 0, "R7 command without grant", gnt_bad, 0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule